// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Counters

This block is a direct-mapped branch predictor for the fetch stage. Each entry stores a tag, the most recent taken target of the branch that owns the entry, a valid bit and a two-bit saturating direction counter. The fetch PC is looked up combinationally, so a predicted target and a taken flag are ready in the same cycle the PC is presented. Because of this, the fetch stage can redirect before decode resolves the branch.

When decode resolves a branch, it reports the branch PC, the resolved target and the outcome on the correction port. The block commits that report at the next rising clock edge. A taken branch that misses in the buffer claims its slot and evicts whatever branch lived there before. A not-taken branch that misses leaves the buffer alone. A branch that hits moves its counter one step toward the outcome. If the outcome was taken, the hit also records the newest target. Because the counters have hysteresis, a single surprise in a strongly biased branch does not flip its prediction.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid: every lookup gives `guess_hit`=0, `guess_taken`=0 and `guess_target`=0.
- R2: The entry index is PC[log2(ENTRIES)+1:2]. The tag is the PC bits above the index. A lookup hits only when the indexed entry is valid and its tag equals the fetch PC tag.
- R3: `guess_hit`, `guess_taken` and `guess_target` depend combinationally on `fetch_pc` and the stored state, with no register in the lookup path.
- R4: `guess_taken` is 1 only on a hit whose counter is 2 or 3. On a hit, `guess_target` shows the stored target. On a miss, `guess_target` is 0.
- R5: A taken correction that misses writes the entry with valid=1, the correction tag, the correction target and counter value 2 (weakly taken).
- R6: A not-taken correction that misses changes no entry.
- R7: A correction that hits moves the counter up by one when taken and down by one when not taken. The counter saturates at 3 and at 0.
- R8: From counter value 3, one not-taken correction leaves the branch predicted taken.
- R9: A taken correction that hits replaces the stored target with the correction target.
- R10: A taken correction whose tag differs from the valid resident tag at the same index overwrites that entry. After that, the old branch misses.
- R11: When a lookup and a correction address the same entry in one cycle, the lookup reports the contents from before the correction.
- R12: With ENTRIES=256, two PCs that are 128 bytes apart use distinct entries. With ENTRIES=32, the same two PCs share an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; corrections are committed on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset that clears all valid bits |
| fetch_pc | input | PC_W | PC being fetched |
| guess_hit | output | 1 | Indexed entry is valid and its tag matches |
| guess_taken | output | 1 | Predicted taken |
| guess_target | output | PC_W | Predicted target when hit, otherwise 0 |
| fix_valid | input | 1 | Correction present this cycle |
| fix_pc | input | PC_W | PC of the resolved branch |
| fix_target | input | PC_W | Resolved target address |
| fix_taken | input | 1 | Resolved outcome |

## Verification
On every cycle, the embedded assertions check reset clearing, allocation on a taken miss, the untouched state after a not-taken miss, counter stepping with saturation, and hysteresis from the strong taken state. The bench's scenarios are the only place that shows tag aliasing and eviction between two branches sharing an index, read-before-write in a single cycle, and index width changing with the entry count. The scenarios also drive each counter through its full range and check that the visible prediction follows each step.

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ENTRIES = 32,
  parameter int PC_W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            guess_hit,
  output logic            guess_taken,
  output logic [PC_W-1:0] guess_target,
  input  logic            fix_valid,
  input  logic [PC_W-1:0] fix_pc,
  input  logic [PC_W-1:0] fix_target,
  input  logic            fix_taken
);
  localparam int IW = $clog2(ENTRIES);
  localparam int TW = PC_W - IW - 2;

  logic [ENTRIES-1:0] vld_q;
  logic [TW-1:0]      tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];

  wire [IW-1:0] f_idx = fetch_pc[IW+1:2];
  wire [TW-1:0] f_tag = fetch_pc[PC_W-1:IW+2];
  wire [IW-1:0] u_idx = fix_pc[IW+1:2];
  wire [TW-1:0] u_tag = fix_pc[PC_W-1:IW+2];

  assign guess_hit    = vld_q[f_idx] && (tag_q[f_idx] == f_tag);
  assign guess_taken  = guess_hit && ctr_q[f_idx][1];
  assign guess_target = guess_hit ? tgt_q[f_idx] : '0;

  wire u_hit = vld_q[u_idx] && (tag_q[u_idx] == u_tag);
  wire wr_en = fix_valid && (u_hit || fix_taken);

  logic [1:0] ctr_nxt;
  always_comb begin
    ctr_nxt = ctr_q[u_idx];
    if (!u_hit)
      ctr_nxt = 2'd2;
    else if (fix_taken)
      ctr_nxt = (ctr_q[u_idx] == 2'd3) ? 2'd3 : ctr_q[u_idx] + 2'd1;
    else
      ctr_nxt = (ctr_q[u_idx] == 2'd0) ? 2'd0 : ctr_q[u_idx] - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[u_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[u_idx] <= u_tag;
      ctr_q[u_idx] <= ctr_nxt;
      if (fix_taken) tgt_q[u_idx] <= fix_target;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> vld_q == '0);

  assert_taken_miss_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_valid && fix_taken && !u_hit) |=>
      (vld_q[$past(u_idx)] && ctr_q[$past(u_idx)] == 2'd2 &&
       tag_q[$past(u_idx)] == $past(u_tag) && tgt_q[$past(u_idx)] == $past(fix_target)));

  assert_nt_miss_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_valid && !fix_taken && !u_hit) |=>
      (vld_q == $past(vld_q) && tag_q[$past(u_idx)] == $past(tag_q[u_idx])));

  assert_ctr_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_valid && u_hit && fix_taken) |=>
      (ctr_q[$past(u_idx)] == 2'd3 || ctr_q[$past(u_idx)] == $past(ctr_q[u_idx]) + 2'd1));

  assert_ctr_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_valid && u_hit && !fix_taken) |=>
      (ctr_q[$past(u_idx)] == 2'd0 || ctr_q[$past(u_idx)] == $past(ctr_q[u_idx]) - 2'd1));

  assert_hysteresis_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_valid && u_hit && !fix_taken && ctr_q[u_idx] == 2'd3) |=> ctr_q[$past(u_idx)][1]);
endmodule

// File: tb/btb_predictor_test.sv
module btb_predictor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] fetch_pc = '0, fix_pc = '0, fix_target = '0;
  logic fix_valid = 1'b0, fix_taken = 1'b0;
  logic s_hit, s_tk, b_hit, b_tk;
  logic [31:0] s_tgt, b_tgt;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  btb_predictor #(.ENTRIES(32), .PC_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .guess_hit(s_hit), .guess_taken(s_tk), .guess_target(s_tgt),
    .fix_valid(fix_valid), .fix_pc(fix_pc), .fix_target(fix_target), .fix_taken(fix_taken));

  btb_predictor #(.ENTRIES(256), .PC_W(32)) uut_big (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .guess_hit(b_hit), .guess_taken(b_tk), .guess_target(b_tgt),
    .fix_valid(fix_valid), .fix_pc(fix_pc), .fix_target(fix_target), .fix_taken(fix_taken));

  typedef struct packed {
    logic        big;
    logic        hit;
    logic        tk;
    logic [31:0] tgt;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];

  task automatic step(input logic [31:0] lpc, input bit uv, input logic [31:0] upc,
                      input logic [31:0] utgt, input bit ut,
                      input bit eh, input bit et, input logic [31:0] etg, input string rq);
    @(negedge clk);
    fetch_pc = lpc; fix_valid = uv; fix_pc = upc; fix_target = utgt; fix_taken = ut;
    exp_q.push_back('{big: 1'b0, hit: eh, tk: et, tgt: etg});
    req_q.push_back(rq);
  endtask

  task automatic expect_big(input bit eh, input bit et, input logic [31:0] etg, input string rq);
    exp_q.push_back('{big: 1'b1, hit: eh, tk: et, tgt: etg});
    req_q.push_back(rq);
  endtask

  task automatic look(input logic [31:0] lpc, input bit eh, input bit et,
                      input logic [31:0] etg, input string rq);
    step(lpc, 1'b0, 32'h0, 32'h0, 1'b0, eh, et, etg, rq);
  endtask

  always @(negedge clk) begin
    #2;
    while (exp_q.size() > 0) begin
      exp_t e;
      string r;
      logic h, t;
      logic [31:0] g;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      h = e.big ? b_hit : s_hit;
      t = e.big ? b_tk  : s_tk;
      g = e.big ? b_tgt : s_tgt;
      compared++;
      if (h !== e.hit || t !== e.tk || g !== e.tgt) begin
        mismatched++;
        $display("FAIL %s: got hit=%0b taken=%0b target=%h, expected hit=%0b taken=%0b target=%h",
                 r, h, t, g, e.hit, e.tk, e.tgt);
      end
    end
  end

  localparam logic [31:0] PA = 32'h0000_0100;
  localparam logic [31:0] PB = 32'h0000_0180;
  localparam logic [31:0] T1 = 32'h0000_4000;
  localparam logic [31:0] T2 = 32'h0000_5000;
  localparam logic [31:0] T3 = 32'h0000_6000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look(PA, 0, 0, 0, "R1");
    look(PB, 0, 0, 0, "R1");
    step(PA, 1, PA, T1, 0, 0, 0, 0, "R6");
    look(PA, 0, 0, 0, "R6");
    step(PA, 1, PA, T1, 1, 0, 0, 0, "R11");
    look(PA, 1, 1, T1, "R5");
    look(PA + 32'd4, 0, 0, 0, "R3");
    look(PA, 1, 1, T1, "R3");
    step(PA, 1, PA, T1, 0, 1, 1, T1, "R11");
    look(PA, 1, 0, T1, "R4");
    step(PA, 1, PA, T1, 0, 1, 0, T1, "R7");
    step(PA, 1, PA, T1, 0, 1, 0, T1, "R7");
    step(PA, 1, PA, T1, 1, 1, 0, T1, "R7");
    look(PA, 1, 0, T1, "R7");
    step(PA, 1, PA, T1, 1, 1, 0, T1, "R7");
    look(PA, 1, 1, T1, "R7");
    step(PA, 1, PA, T2, 1, 1, 1, T1, "R9");
    look(PA, 1, 1, T2, "R9");
    step(PA, 1, PA, T2, 1, 1, 1, T2, "R7");
    step(PA, 1, PA, T2, 0, 1, 1, T2, "R8");
    look(PA, 1, 1, T2, "R8");
    look(PB, 0, 0, 0, "R2");
    step(PB, 1, PB, T3, 1, 0, 0, 0, "R10");
    look(PB, 1, 1, T3, "R10");
    look(PA, 0, 0, 0, "R10");
    expect_big(1, 1, T2, "R12");
    look(PB, 1, 1, T3, "R12");
    expect_big(1, 1, T3, "R12");
    step(PB, 1, PB, T3, 0, 1, 1, T3, "R11");
    look(PB, 1, 0, T3, "R7");
    @(negedge clk);
    rst_n = 1'b0;
    fix_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    look(PB, 0, 0, 0, "R1");
    expect_big(0, 0, 0, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule